// File: doc/BRIEF.md
# Timer Interrupt Output Stage

This block turns the interrupt events of a group of counter/timer channels into interrupt request lines. Each channel receives a one-cycle event strobe from its counter comparator (the comparator itself sits outside the block). The channel answers the strobe in one of two ways. In pulse mode it drops its line for one cycle and then raises it, so that an edge-sensitive interrupt controller sees a fresh rising edge. In toggle mode it inverts an internal active-low request flag and drives the line to the inverse of that flag.

A per-channel arming rule decides whether the channel may answer more than once. In one-shot mode only the first event after a configuration write takes effect. In repeat mode every event takes effect. A write to a channel's configuration register rearms the channel, forces its line low, and tells the counter to restart from zero. An event that arrives in the same cycle as the write is handled as the first event of the new configuration. The stored clock-source field is also decoded into an external-clock select for each channel.

Top module: `tmr_irq_top`

## Requirements
- R1: After reset every interrupt line is 0, every stored configuration is 0, every readback shows the request flag (bit 10) as 1, and every external-clock select and counter-clear output is 0.
- R2: Channel n drives bit 4+n of `irq_out` (n = 0, 1, 2). All other bits of `irq_out` are always 0.
- R3: In pulse mode (configuration bit 7 = 0), an event accepted at a clock edge makes the line 0 after that edge and 1 after the following edge.
- R4: In pulse mode with one-shot arming (configuration bit 6 = 0), events after the first one following a configuration write leave the line unchanged.
- R5: In pulse mode with repeat arming (bit 6 = 1), every event produces the low-then-high sequence of R3.
- R6: In pulse mode the request flag reads back as 1 at all times.
- R7: In toggle mode (bit 7 = 1) with repeat arming, each event inverts the request flag at the event's clock edge, and the line equals the inverse of the flag.
- R8: In toggle mode with one-shot arming, only the first event after a configuration write toggles; later events leave the flag and the line unchanged.
- R9: A configuration write drives the line to 0 and the flag to 1 after its edge, rearms one-shot arming, and raises `cnt_clr` for exactly the next cycle. An event coincident with the write is processed as the first event under the new configuration.
- R10: `rd_data` for the channel picked by `rd_sel` holds the last written bits [9:0] in bits [9:0], the request flag in bit 10, and 0 in bits [15:11]. An out-of-range `rd_sel` reads 0.
- R11: The external-clock select of channel 2 equals clock-source bit 9 of its configuration. For channels 0 and 1 it equals bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 3 | Per-channel configuration write strobe |
| mode_wdata | input | 16 | Configuration write data, shared by all channels |
| evt | input | 3 | Per-channel comparator event strobe |
| rd_sel | input | 2 | Channel whose configuration is shown on `rd_data` |
| rd_data | output | 16 | Configuration readback with the request flag |
| irq_out | output | 11 | Interrupt request lines |
| ext_clk_sel | output | 3 | Per-channel external-clock select |
| cnt_clr | output | 3 | Per-channel one-cycle counter restart |

## Verification
Most internal faults show at the ports within one or two cycles. A stale pending-rise bit leaves the line low one cycle too long. A done flag that fails to clear on a write swallows the first event after it. A wrong flag inversion in toggle mode shows on `irq_out` and on readback bit 10 in the cycle after the event. The bench therefore compares every line, the readback word, the clock selects and the counter clears on every cycle against a model of the requirements. It does this under random events and writes, and adds directed sequences for the one-shot, repeat and write-plus-event cases.

// File: rtl/tmr_irq_pkg.sv
// Package: shared field positions and per-channel state type for the
// timer interrupt output stage. Assumes a 16-bit configuration word.
package tmr_irq_pkg;
    localparam int CFG_W      = 16;
    localparam int STORE_W    = 10;  // bits kept in the configuration register
    localparam int FLAG_BIT   = 10;  // active-low request flag on readback
    localparam int REPEAT_BIT = 6;   // 1 = repeat arming, 0 = one-shot
    localparam int TOGGLE_BIT = 7;   // 1 = toggle output, 0 = pulse output
    localparam int CLKSRC_LO  = 8;   // clock-source field [9:8]

    typedef struct packed {
        logic flag_n;  // active-low request flag
        logic done;    // one-shot already fired
        logic line;    // interrupt line level
        logic pend;    // line dropped this cycle, rise next
    } chan_state_t;
endpackage

// File: rtl/tmr_irq_chan.sv
// One timer channel's interrupt output stage. Holds the configuration
// register and the flag/done/line state. Assumes evt is a one-cycle
// strobe from the counter comparator.
module tmr_irq_chan
    import tmr_irq_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wr,
    input  logic [CFG_W-1:0]   mode_wdata,
    input  logic               evt,
    output logic               line,
    output logic               flag_n,
    output logic               ext_clk,
    output logic               cnt_clr,
    output logic [STORE_W-1:0] cfg
);
    localparam int EXT_BIT = (CH_IDX == 2) ? CLKSRC_LO + 1 : CLKSRC_LO;

    logic [STORE_W-1:0] cfg_q;
    chan_state_t        st_q, st_d;
    logic               clr_q;
    logic [STORE_W-1:0] eff_cfg;
    logic               done_now, flag_now, may_fire;

    // Configuration that governs this cycle's event: the new word on a write.
    always_comb begin
        eff_cfg  = mode_wr ? mode_wdata[STORE_W-1:0] : cfg_q;
        done_now = mode_wr ? 1'b0 : st_q.done;
        flag_now = mode_wr ? 1'b1 : st_q.flag_n;
        may_fire = !done_now || eff_cfg[REPEAT_BIT];
    end

    // Next-state of flag, done and line from write, pending rise and event.
    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d = '{flag_n: 1'b1, done: 1'b0, line: 1'b0, pend: 1'b0};
        end else if (st_q.pend) begin
            st_d.line = 1'b1;
            st_d.pend = 1'b0;
        end
        if (evt) begin
            if (!eff_cfg[TOGGLE_BIT]) begin
                if (may_fire) begin
                    st_d.line = 1'b0;
                    st_d.pend = 1'b1;
                end
                st_d.done   = 1'b1;
                st_d.flag_n = 1'b1;
            end else if (may_fire) begin
                st_d.flag_n = !flag_now;
                st_d.line   = flag_now;
                st_d.done   = 1'b1;
            end
        end
    end

    // State, configuration and counter-clear registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '{flag_n: 1'b1, done: 1'b0, line: 1'b0, pend: 1'b0};
            cfg_q <= '0;
            clr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            clr_q <= mode_wr;
            if (mode_wr) cfg_q <= mode_wdata[STORE_W-1:0];
        end
    end

    assign line    = st_q.line;
    assign flag_n  = st_q.flag_n;
    assign ext_clk = cfg_q[EXT_BIT];
    assign cnt_clr = clr_q;
    assign cfg     = cfg_q;

    // A write without an event leaves the line low and the flag high (R9).
    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && !evt |=> !line && flag_n && cnt_clr);

    // A dropped pulse line rises on the following edge (R3).
    p_pulse_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend && !evt && !mode_wr |=> line);

    // A spent one-shot ignores further events (R4, R8).
    p_oneshot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && !st_q.pend && evt && !mode_wr && !cfg_q[REPEAT_BIT]
        |=> $stable(line) && $stable(flag_n));

    // Pulse mode keeps the request flag high (R6).
    p_pulse_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[TOGGLE_BIT] |-> flag_n);

    // Toggle mode drives the line to the inverse of the flag (R7).
    p_toggle_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[TOGGLE_BIT] |-> line == !flag_n);
endmodule

// File: rtl/tmr_irq_rdmux.sv
// Readback multiplexer: presents one channel's stored configuration with
// its request flag. Assumes a channel count of at least 1.
module tmr_irq_rdmux
    import tmr_irq_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int SEL_W = 2
) (
    input  logic [NCH*STORE_W-1:0] cfg_flat,
    input  logic [NCH-1:0]         flag_n,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [CFG_W-1:0]       rd_data
);
    // Pick the addressed channel; an out-of-range index reads zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(rd_sel) == i) begin
                rd_data[STORE_W-1:0] = cfg_flat[i*STORE_W +: STORE_W];
                rd_data[FLAG_BIT]    = flag_n[i];
            end
        end
    end
endmodule

// File: rtl/tmr_irq_top.sv
// Top: a group of timer interrupt output stages placed on an interrupt
// vector starting at IRQ_BASE. Assumes synchronous active-low reset.
module tmr_irq_top
    import tmr_irq_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int IRQ_BASE = 4,
    parameter int IRQ_W    = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           mode_wr,
    input  logic [CFG_W-1:0]         mode_wdata,
    input  logic [NCH-1:0]           evt,
    input  logic [$clog2(NCH)-1:0]   rd_sel,
    output logic [CFG_W-1:0]         rd_data,
    output logic [IRQ_W-1:0]         irq_out,
    output logic [NCH-1:0]           ext_clk_sel,
    output logic [NCH-1:0]           cnt_clr
);
    localparam int SEL_W = $clog2(NCH);
    localparam logic [IRQ_W-1:0] OWN_MASK = ((IRQ_W'(1) << NCH) - IRQ_W'(1)) << IRQ_BASE;

    logic [NCH-1:0]         line, flag_n;
    logic [NCH*STORE_W-1:0] cfg_flat;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        tmr_irq_chan #(.CH_IDX(n)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_wr   (mode_wr[n]),
            .mode_wdata(mode_wdata),
            .evt       (evt[n]),
            .line      (line[n]),
            .flag_n    (flag_n[n]),
            .ext_clk   (ext_clk_sel[n]),
            .cnt_clr   (cnt_clr[n]),
            .cfg       (cfg_flat[n*STORE_W +: STORE_W])
        );
    end

    // Place channel lines on their interrupt numbers; others stay low.
    always_comb begin
        irq_out = '0;
        irq_out[IRQ_BASE +: NCH] = line;
    end

    tmr_irq_rdmux #(.NCH(NCH), .SEL_W(SEL_W)) u_rd (
        .cfg_flat(cfg_flat),
        .flag_n  (flag_n),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    // Lines outside this block's range never assert (R2).
    p_idle_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~OWN_MASK) == '0);
endmodule

// File: tb/tmr_irq_top_tb.sv
`timescale 1ns/1ps
module tmr_irq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_wr = '0;
    logic [15:0] mode_wdata = '0;
    logic [2:0]  evt = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic [10:0] irq_out;
    logic [2:0]  ext_clk_sel, cnt_clr;

    int checks = 0, fails = 0;

    // Requirement model state
    logic       m_flag[3], m_done[3], m_line[3], m_pend[3], m_clr[3];
    logic [9:0] m_cfg[3];

    localparam logic [15:0] REP = 16'h0040, TOG = 16'h0080;

    always #2.5 clk = ~clk;

    tmr_irq_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .evt(evt), .rd_sel(rd_sel), .rd_data(rd_data), .irq_out(irq_out),
        .ext_clk_sel(ext_clk_sel), .cnt_clr(cnt_clr)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rd(input int s);
        if (s > 2) return 16'h0;
        return {5'b0, m_flag[s], m_cfg[s]};
    endfunction

    function automatic logic [10:0] exp_irq();
        logic [10:0] v = '0;
        for (int i = 0; i < 3; i++) v[4+i] = m_line[i];
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            m_flag[i] = 1; m_done[i] = 0; m_line[i] = 0; m_pend[i] = 0;
            m_clr[i] = 0; m_cfg[i] = '0;
        end
    endtask

    // Advance the model by one edge from the requirement rules.
    task automatic model_step(input logic [2:0] w, input logic [15:0] d, input logic [2:0] e);
        for (int i = 0; i < 3; i++) begin
            logic [9:0] c;
            logic fire, fl;
            m_clr[i] = w[i];
            if (w[i]) begin
                m_cfg[i] = d[9:0];
                m_flag[i] = 1; m_done[i] = 0; m_line[i] = 0; m_pend[i] = 0;
            end else if (m_pend[i]) begin
                m_line[i] = 1; m_pend[i] = 0;
            end
            c = m_cfg[i];
            fire = !m_done[i] || c[6];
            if (e[i]) begin
                if (!c[7]) begin
                    if (fire) begin m_line[i] = 0; m_pend[i] = 1; end
                    m_done[i] = 1; m_flag[i] = 1;
                end else if (fire) begin
                    fl = m_flag[i];
                    m_flag[i] = !fl; m_line[i] = fl; m_done[i] = 1;
                end
            end
        end
    endtask

    task automatic compare_all();
        logic [2:0] ex, cc;
        for (int i = 0; i < 3; i++) begin
            ex[i] = (i == 2) ? m_cfg[i][9] : m_cfg[i][8];
            cc[i] = m_clr[i];
        end
        chk("R2 lines", {5'b0, irq_out}, {5'b0, exp_irq()});
        chk("R10 readback", rd_data, exp_rd(int'(rd_sel)));
        chk("R11 ext clock", {13'b0, ext_clk_sel}, {13'b0, ex});
        chk("R9 counter clear", {13'b0, cnt_clr}, {13'b0, cc});
    endtask

    task automatic cyc(input logic [2:0] w, input logic [15:0] d, input logic [2:0] e,
                       input logic [1:0] s);
        mode_wr = w; mode_wdata = d; evt = e; rd_sel = s;
        @(posedge clk);
        model_step(w, d, e);
        @(negedge clk);
        compare_all();
    endtask

    task automatic line_is(input string tag, input int ch, input logic v);
        chk(tag, {15'b0, irq_out[4+ch]}, {15'b0, v});
    endtask

    task automatic flag_is(input string tag, input int ch, input logic v);
        rd_sel = 2'(ch);
        #0.5;
        chk(tag, {15'b0, rd_data[10]}, {15'b0, v});
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 lines", {5'b0, irq_out}, 16'h0);
        for (int s = 0; s < 3; s++) begin
            rd_sel = 2'(s); #0.2;
            chk("R1 readback", rd_data, 16'h0400);
        end
        chk("R1 ext/clr", {10'b0, ext_clk_sel, cnt_clr}, 16'h0);
        @(negedge clk);

        // R3, R4, R6: pulse one-shot on channel 0
        cyc(3'b001, 16'h0000, 3'b000, 0);  line_is("R9 write low", 0, 0);
        cyc(3'b000, 16'h0000, 3'b001, 0);  line_is("R3 pulse low", 0, 0);
        cyc(3'b000, 16'h0000, 3'b000, 0);  line_is("R3 pulse high", 0, 1);
        flag_is("R6 pulse flag", 0, 1);
        cyc(3'b000, 16'h0000, 3'b001, 0);  line_is("R4 one-shot hold", 0, 1);
        cyc(3'b000, 16'h0000, 3'b000, 0);  line_is("R4 one-shot hold", 0, 1);

        // R5: pulse repeat
        cyc(3'b001, REP, 3'b000, 0);
        for (int k = 0; k < 2; k++) begin
            cyc(3'b000, 16'h0000, 3'b001, 0); line_is("R5 repeat low", 0, 0);
            cyc(3'b000, 16'h0000, 3'b000, 0); line_is("R5 repeat high", 0, 1);
        end

        // R7: toggle repeat on channel 1
        cyc(3'b010, TOG | REP, 3'b000, 1);
        cyc(3'b000, 16'h0000, 3'b010, 1); line_is("R7 toggle up", 1, 1);
        flag_is("R7 flag low", 1, 0);
        cyc(3'b000, 16'h0000, 3'b010, 1); line_is("R7 toggle down", 1, 0);
        flag_is("R7 flag high", 1, 1);

        // R8: toggle one-shot on channel 2, plus R11 clock select
        cyc(3'b101, TOG | 16'h0200, 3'b000, 2);
        chk("R11 ch2 bit9", {15'b0, ext_clk_sel[2]}, 16'h1);
        chk("R11 ch0 bit8", {15'b0, ext_clk_sel[0]}, 16'h0);
        cyc(3'b000, 16'h0000, 3'b100, 2); line_is("R8 first toggle", 2, 1);
        cyc(3'b000, 16'h0000, 3'b100, 2); line_is("R8 ignored", 2, 1);
        flag_is("R8 flag kept", 2, 0);

        // R9: write with coincident event, toggle mode on channel 1
        cyc(3'b010, TOG, 3'b010, 1); line_is("R9 write+event", 1, 1);
        chk("R9 clear pulse", {15'b0, cnt_clr[1]}, 16'h1);
        cyc(3'b000, 16'h0000, 3'b000, 1);
        chk("R9 clear one cycle", {15'b0, cnt_clr[1]}, 16'h0);

        // R10: out-of-range select and field layout
        cyc(3'b001, 16'hFFFF, 3'b000, 0);
        rd_sel = 2'd3; #0.2;
        chk("R10 out of range", rd_data, 16'h0000);
        rd_sel = 2'd0; #0.2;
        chk("R10 layout", rd_data, 16'h07FF);

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] w, e;
            logic [15:0] d;
            for (int i = 0; i < 3; i++) begin
                w[i] = ($urandom % 16) == 0;
                e[i] = ($urandom % 3) == 0;
            end
            d = 16'($urandom);
            cyc(w, d, e, 2'($urandom % 4));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule